// File: doc/BRIEF.md
# SPI-Mode Card Single-Block Write Engine

This block sits behind a byte-wide SPI exchange interface and plays the card's part while a host writes one data block. Each exchange is one strobe cycle. On that cycle the host's byte arrives and the block's reply byte is valid in the same cycle. While idle, the block tells a filler byte, a block start token and a command byte apart. Once the start token has been seen, it forwards each data byte to a storage write port. The data phase ends after a full block, or earlier when storage stops being ready. The block then swallows two CRC bytes without checking them and queues a one-byte "data accepted" reply for the next exchange.

Command bytes are only partly handled here. The block latches the 6-bit command index, counts a fixed number of argument bytes and returns to idle. Acting on the command is left to other logic.

Top module: `card_wr_engine`

## Requirements
- R1: While idle, a received 0xFF is a null command: the reply is 0xFF, the block stays idle and the captured command index does not change.
- R2: While idle, a received 0xFE (block start token) gives a reply of 0xFF and no storage write. The next exchange is the first data byte.
- R3: While idle, any other byte gives a reply of 0xFF. Its bits [5:0] appear on `cmd_idx` after the next rising edge. The next ARG_BYTES (default 4) exchanges are argument bytes, whatever their value: each gives a reply of 0xFF and no storage write. After them the block is idle again.
- R4: In the data phase, each exchange raises `st_we` in that same cycle, with `st_wdata` equal to the received byte, and the reply echoes the received byte.
- R5: The data phase ends after BLOCK_LEN (default 512) data bytes have been written.
- R6: If `st_rdy` is low during a data exchange, that byte is still written and the data phase ends with it.
- R7: The two exchanges after the data phase are CRC bytes. Each gives a reply of 0xFF, no storage write and no check of its value.
- R8: The exchange after the second CRC byte returns 0x05. The block is then idle, and the next block needs a fresh start token.
- R9: While reset is asserted, the reply is 0xFF, `st_we` is low and `cmd_idx` is 0. After reset the block is idle.
- R10: A cycle without `xfer_vld` gives a reply of 0xFF and no storage write, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| xfer_vld | input | 1 | One exchange in this cycle |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Reply byte for this exchange |
| st_rdy | input | 1 | Storage can take more bytes |
| st_we | output | 1 | Storage write enable |
| st_wdata | output | 8 | Storage write data |
| cmd_idx | output | 6 | Last captured command index |

## Verification
`tx_byte`, `st_we` and `st_wdata` respond in the same cycle as the strobe, with no register in their path. The bench drives each exchange on a falling edge and compares these outputs 1 ns later. The effect of an exchange on state, such as a new `cmd_idx`, a phase change or a queued 0x05, shows up only after the next rising edge. The reference model therefore advances on that edge, and the next falling-edge comparison is the first to expect the change. Idle gaps between exchanges are compared the same way, which checks that nothing moves without a strobe.

// File: rtl/card_wr_pkg.sv
package card_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARG,
    ST_DATA,
    ST_CRC,
    ST_RESP
  } cw_state_e;

  localparam logic [7:0] BYTE_IDLE   = 8'hFF;
  localparam logic [7:0] TOKEN_START = 8'hFE;
  localparam logic [7:0] RESP_ACCEPT = 8'h05;
endpackage

// File: rtl/cwe_counter.sv
module cwe_counter #(
  parameter int MAX = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic at_last
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] MAX_V  = W'(MAX);
  localparam logic [W-1:0] LAST_V = W'(MAX - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || inc)  cnt_q <= cnt_d;
  end

  assign at_last = (cnt_q == LAST_V);

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V);
endmodule

// File: rtl/cwe_cmd_capture.sv
module cwe_cmd_capture #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] cmd_idx
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (load) idx_q <= rx_byte[IDX_W-1:0];
  end

  assign cmd_idx = idx_q;

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(idx_q));
endmodule

// File: rtl/cwe_ctrl.sv
module cwe_ctrl
  import card_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_vld,
  input  logic [7:0] rx_byte,
  input  logic       st_rdy,
  input  logic       wr_last,
  input  logic       arg_last,
  output logic [7:0] tx_byte,
  output logic       st_we,
  output logic       wr_inc,
  output logic       wr_clr,
  output logic       arg_inc,
  output logic       arg_clr,
  output logic       cmd_load
);
  cw_state_e  st_q, st_d;
  logic       crc_q, crc_d;
  logic [7:0] resp_q, resp_d;

  always_comb begin
    st_d     = st_q;
    crc_d    = crc_q;
    resp_d   = resp_q;
    tx_byte  = BYTE_IDLE;
    st_we    = 1'b0;
    wr_inc   = 1'b0;
    wr_clr   = 1'b0;
    arg_inc  = 1'b0;
    arg_clr  = 1'b0;
    cmd_load = 1'b0;
    if (xfer_vld) begin
      unique case (st_q)
        ST_IDLE: begin
          if (rx_byte == TOKEN_START) begin
            st_d = ST_DATA;
          end else if (rx_byte != BYTE_IDLE) begin
            cmd_load = 1'b1;
            arg_clr  = 1'b1;
            st_d     = ST_ARG;
          end
        end
        ST_ARG: begin
          arg_inc = 1'b1;
          if (arg_last) begin
            arg_clr = 1'b1;
            st_d    = ST_IDLE;
          end
        end
        ST_DATA: begin
          st_we   = 1'b1;
          tx_byte = rx_byte;
          wr_inc  = 1'b1;
          if (!st_rdy || wr_last) begin
            st_d  = ST_CRC;
            crc_d = 1'b0;
          end
        end
        ST_CRC: begin
          if (crc_q) begin
            st_d   = ST_RESP;
            crc_d  = 1'b0;
            wr_clr = 1'b1;
            resp_d = RESP_ACCEPT;
          end else begin
            crc_d  = 1'b1;
          end
        end
        ST_RESP: begin
          tx_byte = resp_q;
          st_d    = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      crc_q  <= 1'b0;
      resp_q <= 8'h00;
    end else if (xfer_vld) begin
      st_q   <= st_d;
      crc_q  <= crc_d;
      resp_q <= resp_d;
    end
  end

  assert_null_stays_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && xfer_vld && rx_byte == BYTE_IDLE) |=> st_q == ST_IDLE);
  assert_token_enters_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && xfer_vld && rx_byte == TOKEN_START) |=> st_q == ST_DATA);
  assert_early_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && xfer_vld && !st_rdy) |=> st_q == ST_CRC);
  assert_crc_to_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CRC && xfer_vld && crc_q) |=> (st_q == ST_RESP && resp_q == RESP_ACCEPT));
  assert_resp_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESP && xfer_vld) |=> st_q == ST_IDLE);
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_vld |=> $stable(st_q));
endmodule

// File: rtl/card_wr_engine.sv
module card_wr_engine #(
  parameter int BLOCK_LEN = 512,
  parameter int ARG_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_vld,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte,
  input  logic       st_rdy,
  output logic       st_we,
  output logic [7:0] st_wdata,
  output logic [5:0] cmd_idx
);
  logic wr_last, arg_last;
  logic wr_inc, wr_clr, arg_inc, arg_clr, cmd_load;

  cwe_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_vld (xfer_vld),
    .rx_byte  (rx_byte),
    .st_rdy   (st_rdy),
    .wr_last  (wr_last),
    .arg_last (arg_last),
    .tx_byte  (tx_byte),
    .st_we    (st_we),
    .wr_inc   (wr_inc),
    .wr_clr   (wr_clr),
    .arg_inc  (arg_inc),
    .arg_clr  (arg_clr),
    .cmd_load (cmd_load)
  );

  cwe_counter #(.MAX(BLOCK_LEN)) u_wr_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (wr_inc),
    .clr     (wr_clr),
    .at_last (wr_last)
  );

  cwe_counter #(.MAX(ARG_BYTES)) u_arg_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (arg_inc),
    .clr     (arg_clr),
    .at_last (arg_last)
  );

  cwe_cmd_capture #(.IDX_W(6)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_load),
    .rx_byte (rx_byte),
    .cmd_idx (cmd_idx)
  );

  assign st_wdata = rx_byte;

  assert_we_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> xfer_vld);
endmodule

// File: tb/sim_card_wr_engine.sv
module sim_card_wr_engine;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       xfer_vld;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte;
  logic       st_rdy;
  logic       st_we;
  logic [7:0] st_wdata;
  logic [5:0] cmd_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state: 0 idle, 1 arg, 2 data, 3 crc, 4 resp
  int m_st = 0;
  int m_cnt = 0;
  int m_arg = 0;
  int m_crc = 0;
  int m_cmd = 0;
  int resp_q[$];
  logic [7:0] lfsr = 8'h5A;

  always #4 clk = ~clk;

  card_wr_engine u0 (
    .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .st_rdy(st_rdy), .st_we(st_we),
    .st_wdata(st_wdata), .cmd_idx(cmd_idx)
  );

  task automatic compare(string req, int exp_tx, int exp_we, int exp_wd);
    n_vec++;
    if (tx_byte !== 8'(exp_tx) || st_we !== 1'(exp_we) ||
        (exp_we != 0 && st_wdata !== 8'(exp_wd)) || cmd_idx !== 6'(m_cmd)) begin
      n_bad++;
      $display("FAIL %s: tx=%02h we=%0b wd=%02h cmd=%02h expected tx=%02h we=%0d wd=%02h cmd=%02h",
               req, tx_byte, st_we, st_wdata, cmd_idx, exp_tx, exp_we, exp_wd, m_cmd);
    end
  endtask

  task automatic step(bit vld, logic [7:0] b, bit rdy);
    string req;
    int etx, ewe;
    @(negedge clk);
    xfer_vld = vld; rx_byte = b; st_rdy = rdy;
    #1;
    etx = 8'hFF; ewe = 0; req = "R10";
    if (vld) begin
      case (m_st)
        0: req = (b == 8'hFF) ? "R1" : (b == 8'hFE) ? "R2" : "R3";
        1: req = "R3";
        2: begin
             etx = b; ewe = 1;
             req = !rdy ? "R6" : (m_cnt == 511) ? "R5" : "R4";
           end
        3: req = "R7";
        default: begin req = "R8"; etx = resp_q[0]; end
      endcase
    end
    compare(req, etx, ewe, b);
    @(posedge clk);
    if (vld) begin
      case (m_st)
        0: if (b == 8'hFE) m_st = 2;
           else if (b != 8'hFF) begin m_cmd = b & 8'h3F; m_arg = 0; m_st = 1; end
        1: begin m_arg++; if (m_arg == 4) begin m_arg = 0; m_st = 0; end end
        2: begin m_cnt++; if (!rdy || m_cnt == 512) begin m_crc = 0; m_st = 3; end end
        3: begin m_crc++; if (m_crc == 2) begin m_cnt = 0; resp_q.push_back(8'h05); m_st = 4; end end
        default: begin void'(resp_q.pop_front()); m_st = 0; end
      endcase
    end
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr;
  endfunction

  task automatic write_block(int n, int stop_at);
    step(1, 8'hFE, 1);
    for (int i = 0; i < n; i++) begin
      step(1, next_rand(), (i != stop_at));
      if (m_st != 2) break;
      if (i % 97 == 0) step(0, 8'hFE, 1);
    end
    step(1, 8'hA5, 1);
    step(0, 8'h00, 1);
    step(1, 8'h3C, 1);
    step(1, 8'hFF, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xfer_vld = 0; rx_byte = 8'h00; st_rdy = 1;
    @(negedge clk); #1;
    compare("R9", 8'hFF, 0, 0);
    @(negedge clk); xfer_vld = 1; rx_byte = 8'hFE; #1;
    compare("R9", 8'hFF, 0, 0);
    @(negedge clk); xfer_vld = 0; rst_n = 1;
    step(1, 8'hFF, 1);
    step(1, 8'hFF, 1);
    step(0, 8'h12, 1);
    // command with argument bytes that look like tokens
    step(1, 8'h51, 1);
    step(1, 8'hFE, 1);
    step(1, 8'hFF, 1);
    step(0, 8'h00, 1);
    step(1, 8'h00, 1);
    step(1, 8'h02, 1);
    step(1, 8'hFF, 1);
    // full block
    write_block(512, -1);
    // early stop
    write_block(512, 36);
    // stop on first byte
    write_block(512, 0);
    // another command, upper bits set
    step(1, 8'hFA, 1);
    for (int i = 0; i < 4; i++) step(1, 8'(i), 1);
    step(1, 8'hFF, 1);
    // reset in the middle of a data phase
    step(1, 8'hFE, 1);
    step(1, 8'h11, 1);
    @(negedge clk); rst_n = 0; xfer_vld = 0; #1;
    m_st = 0; m_cnt = 0; m_arg = 0; m_crc = 0; m_cmd = 0; resp_q.delete();
    compare("R9", 8'hFF, 0, 0);
    @(negedge clk); rst_n = 1;
    step(1, 8'h33, 1);
    step(1, 8'hFF, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule